// File: doc/BRIEF.md
# Register Renaming Buffer with Architectural Map

This block gives out-of-order execution a way to rename destination registers. A small ring of rename slots sits beside the architectural register file. Each architectural register carries a busy flag and the number of the slot that will produce its next value. At dispatch, the two source operands are looked up. A register that is not busy returns its committed value. A busy register whose slot already holds a result returns that result. A busy register whose slot is still waiting returns only the slot number, which is the tag that a later result broadcast will carry.

Each dispatched instruction writes one destination register and takes the next free slot in ring order. Its destination register is then marked busy with that slot's number. Execution units return results by slot number. A completion request retires the oldest slot, and only once its result has arrived: the value is copied into the architectural file and the slot is released. A flush drops every slot in flight. It rewinds the allocation pointer onto the retirement pointer and clears all busy flags, so only committed values remain visible.

Top module: `rrf_rename_unit`

## Requirements
- R1: After reset, `dsp_ready` is 1, `dsp_tag` and `cmt_tag` are 0, and every source read returns `srcN_pend`=0 with `srcN_data`=0.
- R2: A source read of a register that is not busy returns its committed value with `srcN_pend`=0 and `srcN_tag`=0.
- R3: A dispatch (`dsp_valid`=1 while `dsp_ready`=1 and `flush`=0) takes the slot shown on `dsp_tag`. The next slot number is the previous one plus one, modulo RRF_DEPTH. The destination register then reads as busy on that slot. The source reads of the same cycle show the mapping as it was before this dispatch.
- R4: A source read of a busy register whose slot has no result yet returns `srcN_pend`=1, `srcN_tag` equal to the slot number, and `srcN_data`=0.
- R5: `res_valid` with `res_tag` naming an in-flight slot stores `res_data` there. From the next cycle, a read of the register mapped to that slot returns the data with `srcN_pend`=0.
- R6: With `cmt_en`=1, the oldest slot retires only when its result has arrived. `cmt_fire`=1 in that cycle, with `cmt_reg` and `cmt_data` giving the register and its value. The value is written into the architectural file, and `cmt_tag` advances by one modulo RRF_DEPTH. A younger slot that has finished never retires ahead of an older one.
- R7: When a slot retires, its register's busy flag is cleared only if the register still maps to that slot. A register remapped by a younger dispatch stays busy on the younger slot.
- R8: When RRF_DEPTH slots are in flight, `dsp_ready`=0 and a dispatch request has no effect. The next retirement sets `dsp_ready` to 1 again.
- R9: `flush`=1 blocks any dispatch and retirement in its cycle. It clears every busy flag and every slot result, sets `dsp_tag` to the current `cmt_tag`, and leaves committed values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_valid | input | 1 | Dispatch request for one instruction with a destination |
| dsp_src0 | input | IDX_W | First source register number |
| dsp_src1 | input | IDX_W | Second source register number |
| dsp_dst | input | IDX_W | Destination register number |
| dsp_ready | output | 1 | A free slot is available |
| dsp_tag | output | TAG_W | Slot that the next dispatch takes |
| src0_pend | output | 1 | First source is waiting on a slot |
| src0_data | output | DATA_W | First source value (0 while pending) |
| src0_tag | output | TAG_W | Slot producing the first source |
| src1_pend | output | 1 | Second source is waiting on a slot |
| src1_data | output | DATA_W | Second source value (0 while pending) |
| src1_tag | output | TAG_W | Slot producing the second source |
| res_valid | input | 1 | Execution result write |
| res_tag | input | TAG_W | Slot the result belongs to |
| res_data | input | DATA_W | Result value |
| cmt_en | input | 1 | Request to retire the oldest slot |
| cmt_fire | output | 1 | The oldest slot retires this cycle |
| cmt_tag | output | TAG_W | Oldest slot number |
| cmt_reg | output | IDX_W | Register written by the retiring slot |
| cmt_data | output | DATA_W | Value written by the retiring slot |
| flush | input | 1 | Discard all slots in flight |

## Verification
The properties assume that `res_tag` only names a slot that is in flight. They also assume that each slot gets at most one result, and that no result arrives in the same cycle as a flush. The directed stimulus meets these assumptions: every result it sends goes to a slot number it read from `dsp_tag` at dispatch, and its results never overlap a flush. The bench also offers dispatch requests and retirement requests while the ring is full or empty and during the flush cycle itself. This shows that the pointer properties hold for requests the block has to refuse.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
   localparam int ARCH_REGS_DEF = 32;
   localparam int RRF_DEPTH_DEF = 8;
   localparam int DATA_W_DEF    = 32;
   localparam int SRC_PORTS     = 2;

   typedef enum logic [1:0] {
      SRC_FROM_ARCH  = 2'd0,
      SRC_FROM_SLOT  = 2'd1,
      SRC_WAIT_SLOT  = 2'd2
   } src_origin_e;
endpackage

// File: rtl/rrf_arch_file.sv
module rrf_arch_file #(
   parameter int NREG   = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5,
   parameter int TAG_W  = 3,
   parameter int NRD    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
   output logic [NRD-1:0][DATA_W-1:0]  rd_data,
   output logic [NRD-1:0]              rd_busy,
   output logic [NRD-1:0][TAG_W-1:0]   rd_tag,
   input  logic                        map_we,
   input  logic [IDX_W-1:0]            map_idx,
   input  logic [TAG_W-1:0]            map_tag,
   input  logic                        ret_we,
   input  logic [IDX_W-1:0]            ret_idx,
   input  logic [TAG_W-1:0]            ret_tag,
   input  logic [DATA_W-1:0]           ret_data,
   input  logic                        flush
);
   logic [DATA_W-1:0] a_data [NREG];
   logic [TAG_W-1:0]  a_tag  [NREG];
   logic [NREG-1:0]   a_busy;

   if (NREG < 2 || (1 << IDX_W) < NREG) begin : g_bad_idx
      $error("rrf_arch_file: IDX_W too narrow for NREG");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic hit_map, hit_ret;
      assign hit_map = map_we && (map_idx == IDX_W'(i));
      assign hit_ret = ret_we && (ret_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            a_data[i] <= '0;
            a_tag[i]  <= '0;
            a_busy[i] <= 1'b0;
         end else begin
            if (hit_ret) a_data[i] <= ret_data;
            if (flush) begin
               a_busy[i] <= 1'b0;
            end else if (hit_map) begin
               a_busy[i] <= 1'b1;
               a_tag[i]  <= map_tag;
            end else if (hit_ret && (a_tag[i] == ret_tag)) begin
               a_busy[i] <= 1'b0;
            end
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = a_data[rd_idx[p]];
      assign rd_busy[p] = a_busy[rd_idx[p]];
      assign rd_tag[p]  = a_tag[rd_idx[p]];
   end
endmodule

// File: rtl/rrf_slot_ring.sv
module rrf_slot_ring #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5,
   parameter int TAG_W  = 3,
   parameter int NRD    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        alloc_req,
   input  logic [IDX_W-1:0]            alloc_idx,
   output logic                        alloc_fire,
   output logic [TAG_W-1:0]            alloc_tag,
   output logic                        full,
   input  logic                        wr_en,
   input  logic [TAG_W-1:0]            wr_tag,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic [NRD-1:0][TAG_W-1:0]   rd_tag,
   output logic [NRD-1:0][DATA_W-1:0]  rd_data,
   output logic [NRD-1:0]              rd_done,
   input  logic                        ret_req,
   output logic                        ret_fire,
   output logic [TAG_W-1:0]            ret_tag,
   output logic [IDX_W-1:0]            ret_idx,
   output logic [DATA_W-1:0]           ret_data,
   input  logic                        flush
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   logic [DATA_W-1:0] s_data [DEPTH];
   logic [IDX_W-1:0]  s_dst  [DEPTH];
   logic [DEPTH-1:0]  s_used;
   logic [DEPTH-1:0]  s_done;
   logic [TAG_W-1:0]  head_q, tail_q, head_nxt, tail_nxt;
   logic [CNT_W-1:0]  cnt_q;

   if (DEPTH < 2 || (1 << TAG_W) < DEPTH) begin : g_bad_depth
      $error("rrf_slot_ring: TAG_W too narrow for DEPTH");
   end

   if (POW2) begin : g_wrap_pow2
      assign head_nxt = head_q + TAG_W'(1);
      assign tail_nxt = tail_q + TAG_W'(1);
   end else begin : g_wrap_cmp
      assign head_nxt = (head_q == TAG_W'(DEPTH - 1)) ? '0 : head_q + TAG_W'(1);
      assign tail_nxt = (tail_q == TAG_W'(DEPTH - 1)) ? '0 : tail_q + TAG_W'(1);
   end

   assign full       = (cnt_q == CNT_W'(DEPTH));
   assign alloc_fire = alloc_req && !full && !flush;
   assign alloc_tag  = head_q;
   assign ret_tag    = tail_q;
   assign ret_idx    = s_dst[tail_q];
   assign ret_data   = s_data[tail_q];
   assign ret_fire   = ret_req && !flush && s_used[tail_q] && s_done[tail_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         head_q <= tail_q;
         cnt_q  <= '0;
      end else begin
         if (alloc_fire) head_q <= head_nxt;
         if (ret_fire)   tail_q <= tail_nxt;
         cnt_q <= cnt_q + CNT_W'(alloc_fire) - CNT_W'(ret_fire);
      end
   end

   for (genvar j = 0; j < DEPTH; j++) begin : g_slot
      logic take, leave, fill;
      assign take  = alloc_fire && (head_q == TAG_W'(j));
      assign leave = ret_fire && (tail_q == TAG_W'(j));
      assign fill  = wr_en && s_used[j] && (wr_tag == TAG_W'(j));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_used[j] <= 1'b0;
            s_done[j] <= 1'b0;
            s_data[j] <= '0;
            s_dst[j]  <= '0;
         end else if (flush) begin
            s_used[j] <= 1'b0;
            s_done[j] <= 1'b0;
         end else begin
            if (fill) begin
               s_done[j] <= 1'b1;
               s_data[j] <= wr_data;
            end
            if (take) begin
               s_used[j] <= 1'b1;
               s_done[j] <= 1'b0;
               s_dst[j]  <= alloc_idx;
            end else if (leave) begin
               s_used[j] <= 1'b0;
               s_done[j] <= 1'b0;
            end
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = s_data[rd_tag[p]];
      assign rd_done[p] = s_done[rd_tag[p]];
   end
endmodule

// File: rtl/rrf_rename_unit.sv
module rrf_rename_unit #(
   parameter int ARCH_REGS = rrf_pkg::ARCH_REGS_DEF,
   parameter int RRF_DEPTH = rrf_pkg::RRF_DEPTH_DEF,
   parameter int DATA_W    = rrf_pkg::DATA_W_DEF,
   parameter int IDX_W     = $clog2(ARCH_REGS),
   parameter int TAG_W     = $clog2(RRF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dsp_valid,
   input  logic [IDX_W-1:0]  dsp_src0,
   input  logic [IDX_W-1:0]  dsp_src1,
   input  logic [IDX_W-1:0]  dsp_dst,
   output logic              dsp_ready,
   output logic [TAG_W-1:0]  dsp_tag,
   output logic              src0_pend,
   output logic [DATA_W-1:0] src0_data,
   output logic [TAG_W-1:0]  src0_tag,
   output logic              src1_pend,
   output logic [DATA_W-1:0] src1_data,
   output logic [TAG_W-1:0]  src1_tag,
   input  logic              res_valid,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic [DATA_W-1:0] res_data,
   input  logic              cmt_en,
   output logic              cmt_fire,
   output logic [TAG_W-1:0]  cmt_tag,
   output logic [IDX_W-1:0]  cmt_reg,
   output logic [DATA_W-1:0] cmt_data,
   input  logic              flush
);
   import rrf_pkg::*;
   localparam int NRD = SRC_PORTS;

   if (DATA_W < 1) begin : g_bad_data
      $error("rrf_rename_unit: DATA_W must be positive");
   end
   if (RRF_DEPTH < 2) begin : g_bad_ring
      $error("rrf_rename_unit: RRF_DEPTH must be at least 2");
   end

   logic [NRD-1:0][IDX_W-1:0]  rd_idx;
   logic [NRD-1:0][DATA_W-1:0] a_rd_data, s_rd_data, op_data;
   logic [NRD-1:0]             a_rd_busy, s_rd_done, op_pend;
   logic [NRD-1:0][TAG_W-1:0]  a_rd_tag, op_tag;
   src_origin_e                op_from [NRD];
   logic                       alloc_fire, ring_full;

   assign rd_idx[0] = dsp_src0;
   assign rd_idx[1] = dsp_src1;

   rrf_arch_file #(
      .NREG(ARCH_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .NRD(NRD)
   ) u_arch (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx), .rd_data(a_rd_data), .rd_busy(a_rd_busy), .rd_tag(a_rd_tag),
      .map_we(alloc_fire), .map_idx(dsp_dst), .map_tag(dsp_tag),
      .ret_we(cmt_fire), .ret_idx(cmt_reg), .ret_tag(cmt_tag), .ret_data(cmt_data),
      .flush(flush)
   );

   rrf_slot_ring #(
      .DEPTH(RRF_DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .NRD(NRD)
   ) u_ring (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(dsp_valid), .alloc_idx(dsp_dst), .alloc_fire(alloc_fire),
      .alloc_tag(dsp_tag), .full(ring_full),
      .wr_en(res_valid), .wr_tag(res_tag), .wr_data(res_data),
      .rd_tag(a_rd_tag), .rd_data(s_rd_data), .rd_done(s_rd_done),
      .ret_req(cmt_en), .ret_fire(cmt_fire), .ret_tag(cmt_tag),
      .ret_idx(cmt_reg), .ret_data(cmt_data),
      .flush(flush)
   );

   assign dsp_ready = !ring_full;

   for (genvar p = 0; p < NRD; p++) begin : g_src
      always_comb begin
         if (!a_rd_busy[p])     op_from[p] = SRC_FROM_ARCH;
         else if (s_rd_done[p]) op_from[p] = SRC_FROM_SLOT;
         else                   op_from[p] = SRC_WAIT_SLOT;
      end

      always_comb begin
         op_pend[p] = 1'b0;
         op_tag[p]  = '0;
         op_data[p] = a_rd_data[p];
         unique case (op_from[p])
            SRC_FROM_SLOT: begin
               op_tag[p]  = a_rd_tag[p];
               op_data[p] = s_rd_data[p];
            end
            SRC_WAIT_SLOT: begin
               op_tag[p]  = a_rd_tag[p];
               op_data[p] = '0;
               op_pend[p] = 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign src0_pend = op_pend[0];
   assign src0_data = op_data[0];
   assign src0_tag  = op_tag[0];
   assign src1_pend = op_pend[1];
   assign src1_data = op_data[1];
   assign src1_tag  = op_tag[1];
endmodule

// File: rtl/rrf_rename_unit_chk.sv
module rrf_rename_unit_chk #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dsp_valid,
   input logic             dsp_ready,
   input logic [TAG_W-1:0] dsp_tag,
   input logic             cmt_fire,
   input logic [TAG_W-1:0] cmt_tag,
   input logic             flush
);
   function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] v);
      return (v == TAG_W'(DEPTH - 1)) ? '0 : v + TAG_W'(1);
   endfunction

   p_alloc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_valid && dsp_ready && !flush) |=> dsp_tag == step($past(dsp_tag)));

   p_alloc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(dsp_valid && dsp_ready) && !flush) |=> $stable(dsp_tag));

   p_stay_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dsp_ready && !cmt_fire && !flush) |=> !dsp_ready);

   p_retire_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_fire |=> cmt_tag == step($past(cmt_tag)));

   p_retire_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cmt_fire |=> $stable(cmt_tag));

   p_flush_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (dsp_tag == $past(cmt_tag)) && dsp_ready);

   p_flush_no_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !cmt_fire);
endmodule

bind rrf_rename_unit rrf_rename_unit_chk #(.DEPTH(RRF_DEPTH), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dsp_valid(dsp_valid), .dsp_ready(dsp_ready),
   .dsp_tag(dsp_tag), .cmt_fire(cmt_fire), .cmt_tag(cmt_tag), .flush(flush)
);

// File: tb/rrf_rename_unit_bench.sv
`timescale 1ns/1ps
module rrf_rename_unit_bench;
   localparam int NR = 32, DP = 8, DW = 32, IW = 5, TW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic dsp_valid = 0, res_valid = 0, cmt_en = 0, flush = 0;
   logic [IW-1:0] dsp_src0 = '0, dsp_src1 = '0, dsp_dst = '0;
   logic [TW-1:0] res_tag = '0;
   logic [DW-1:0] res_data = '0;
   logic dsp_ready, src0_pend, src1_pend, cmt_fire;
   logic [TW-1:0] dsp_tag, src0_tag, src1_tag, cmt_tag;
   logic [DW-1:0] src0_data, src1_data, cmt_data;
   logic [IW-1:0] cmt_reg;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // values sampled by the tasks just before the active edge
   logic s_rdy, s_p0, s_p1, s_fire;
   logic [TW-1:0] s_tag, s_t0, s_t1, s_ctag;
   logic [DW-1:0] s_d0, s_d1, s_cdata;
   logic [IW-1:0] s_creg;

   always #2 clk = ~clk;

   rrf_rename_unit #(.ARCH_REGS(NR), .RRF_DEPTH(DP), .DATA_W(DW)) u_rrf_rename_unit (
      .clk(clk), .rst_n(rst_n), .dsp_valid(dsp_valid), .dsp_src0(dsp_src0),
      .dsp_src1(dsp_src1), .dsp_dst(dsp_dst), .dsp_ready(dsp_ready), .dsp_tag(dsp_tag),
      .src0_pend(src0_pend), .src0_data(src0_data), .src0_tag(src0_tag),
      .src1_pend(src1_pend), .src1_data(src1_data), .src1_tag(src1_tag),
      .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
      .cmt_en(cmt_en), .cmt_fire(cmt_fire), .cmt_tag(cmt_tag), .cmt_reg(cmt_reg),
      .cmt_data(cmt_data), .flush(flush));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic sample();
      s_rdy = dsp_ready; s_tag = dsp_tag;
      s_p0 = src0_pend; s_d0 = src0_data; s_t0 = src0_tag;
      s_p1 = src1_pend; s_d1 = src1_data; s_t1 = src1_tag;
      s_fire = cmt_fire; s_ctag = cmt_tag; s_creg = cmt_reg; s_cdata = cmt_data;
   endtask

   task automatic idle_inputs();
      dsp_valid = 0; res_valid = 0; cmt_en = 0; flush = 0;
   endtask

   // one cycle with the given controls; outputs sampled before the edge
   task automatic cycle(input bit dv, input logic [IW-1:0] dst, input logic [IW-1:0] a,
                        input logic [IW-1:0] b, input bit rv, input logic [TW-1:0] rt,
                        input logic [DW-1:0] rd, input bit ce, input bit fl);
      @(negedge clk);
      dsp_valid = dv; dsp_dst = dst; dsp_src0 = a; dsp_src1 = b;
      res_valid = rv; res_tag = rt; res_data = rd; cmt_en = ce; flush = fl;
      #1 sample();
      @(posedge clk);
      #1 idle_inputs();
   endtask

   task automatic dispatch(input logic [IW-1:0] dst, input logic [IW-1:0] a, input logic [IW-1:0] b);
      cycle(1, dst, a, b, 0, '0, '0, 0, 0);
   endtask
   task automatic probe(input logic [IW-1:0] a, input logic [IW-1:0] b);
      cycle(0, '0, a, b, 0, '0, '0, 0, 0);
   endtask
   task automatic result(input logic [TW-1:0] t, input logic [DW-1:0] d);
      cycle(0, '0, '0, '0, 1, t, d, 0, 0);
   endtask
   task automatic retire();
      cycle(0, '0, '0, '0, 0, '0, '0, 1, 0);
   endtask

   task automatic t_reset();
      probe(5, 31);
      chk(s_rdy == 1, "R1 ready", 32'(s_rdy), 1);
      chk(s_tag == 0 && s_ctag == 0, "R1 pointers", {s_tag, s_ctag}, 0);
      chk(!s_p0 && s_d0 == 0 && !s_p1 && s_d1 == 0, "R1 reads", s_d0 | 32'(s_p0), 0);
   endtask

   task automatic t_basic();
      dispatch(3, 7, 3);
      chk(s_tag == 0, "R3 first slot", 32'(s_tag), 0);
      chk(!s_p0 && s_d0 == 0 && s_t0 == 0, "R2 idle register", s_d0, 0);
      chk(!s_p1, "R3 own source sees old map", 32'(s_p1), 0);
      probe(3, 7);
      chk(s_p0 && s_t0 == 0 && s_d0 == 0, "R4 pending tag", {s_t0, 28'(s_d0)}, 0);
      result(0, 32'hAAAA_0001);
      probe(3, 3);
      chk(!s_p0 && s_d0 == 32'hAAAA_0001, "R5 data after result", s_d0, 32'hAAAA_0001);
      retire();
      chk(s_fire && s_creg == 3 && s_cdata == 32'hAAAA_0001, "R6 retire outputs", s_cdata, 32'hAAAA_0001);
      probe(3, 0);
      chk(!s_p0 && s_d0 == 32'hAAAA_0001 && s_t0 == 0, "R2 committed value", s_d0, 32'hAAAA_0001);
      chk(s_ctag == 1, "R6 retire pointer", 32'(s_ctag), 1);
   endtask

   task automatic t_inorder();
      dispatch(4, 0, 0);
      chk(s_tag == 1, "R3 slot order", 32'(s_tag), 1);
      dispatch(5, 4, 0);
      chk(s_tag == 2 && s_p0 && s_t0 == 1, "R4 chained tag", 32'(s_t0), 1);
      result(2, 32'h0000_0505);
      retire();
      chk(!s_fire && s_ctag == 1, "R6 younger cannot pass", 32'(s_fire), 0);
      result(1, 32'h0000_0404);
      retire();
      chk(s_fire && s_creg == 4 && s_cdata == 32'h404, "R6 oldest first", s_cdata, 32'h404);
      retire();
      chk(s_fire && s_creg == 5 && s_cdata == 32'h505, "R6 second in order", s_cdata, 32'h505);
      probe(4, 5);
      chk(s_d0 == 32'h404 && s_d1 == 32'h505 && !s_p0 && !s_p1, "R6 file updated", s_d1, 32'h505);
   endtask

   task automatic t_remap();
      dispatch(6, 6, 0);
      chk(s_tag == 3 && !s_p0, "R3 self source", 32'(s_p0), 0);
      dispatch(6, 6, 0);
      chk(s_tag == 4 && s_p0 && s_t0 == 3, "R3 remap reads older slot", 32'(s_t0), 3);
      result(3, 32'h11);
      retire();
      chk(s_fire && s_creg == 6, "R6 retire older writer", 32'(s_creg), 6);
      probe(6, 0);
      chk(s_p0 && s_t0 == 4, "R7 stays busy on younger slot", {s_t0, 28'(s_p0)}, {3'd4, 28'd1});
      result(4, 32'h22);
      retire();
      probe(6, 0);
      chk(!s_p0 && s_d0 == 32'h22, "R7 younger value lands", s_d0, 32'h22);
   endtask

   task automatic t_full_flush();
      for (int k = 0; k < DP; k++) begin
         dispatch(IW'(10 + k), 0, 0);
         chk(s_rdy && s_tag == TW'((5 + k) % DP), "R3 wrap order", 32'(s_tag), 32'((5 + k) % DP));
      end
      dispatch(20, 20, 0);
      chk(!s_rdy, "R8 full stalls", 32'(s_rdy), 0);
      probe(20, 0);
      chk(s_tag == 5 && !s_p0, "R8 refused dispatch ignored", {s_tag, 28'(s_p0)}, {3'd5, 28'd0});
      result(5, 32'h55);
      retire();
      chk(s_fire && s_creg == 10, "R6 retire under full", 32'(s_creg), 10);
      probe(0, 0);
      chk(s_rdy, "R8 ready after retire", 32'(s_rdy), 1);
      result(6, 32'h66);
      cycle(1, 21, 11, 10, 0, '0, '0, 1, 1);
      chk(!s_fire, "R9 flush blocks retire", 32'(s_fire), 0);
      probe(11, 10);
      chk(s_tag == 6 && s_ctag == 6 && s_rdy, "R9 rewind", {s_tag, s_ctag}, {3'd6, 3'd6});
      chk(!s_p0 && s_d0 == 0, "R9 busy cleared", s_d0, 0);
      chk(!s_p1 && s_d1 == 32'h55, "R9 committed kept", s_d1, 32'h55);
      probe(21, 12);
      chk(!s_p0 && !s_p1, "R9 flush-cycle dispatch dropped", {31'(s_p0), s_p1}, 0);
      retire();
      chk(!s_fire, "R9 slot result discarded", 32'(s_fire), 0);
      dispatch(11, 10, 0);
      chk(s_tag == 6 && s_d0 == 32'h55, "R3 reuse after flush", 32'(s_tag), 6);
      result(6, 32'h77);
      retire();
      chk(s_fire && s_creg == 11 && s_cdata == 32'h77, "R6 retire after flush", s_cdata, 32'h77);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_basic();
      t_inorder();
      t_remap();
      t_full_flush();
      repeat (2) @(posedge clk);
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end
endmodule